// File: doc/BRIEF.md
# Pipeline Stage Enable Sequencer

This block paces a multi-stage arithmetic pipeline in which every stage is given a fixed number of clock cycles to settle before its result is captured. A cycle counter runs through a dwell window of fixed length, and a stage index names the stage that owns the current window. In the final cycle of each window the enable of that stage pulses for one cycle, so its pipeline register captures a settled result. The index then moves to the next stage, and after the last stage it returns to the first.

With the default sizing of ten stages and a dwell of 100 cycles, a 50 MHz clock gives each stage 2 µs. A full pass over all stages takes 20 µs. A frame strobe pulses together with the last stage's enable to mark each new controller output handed to the modulator. A run input pauses the sequence without losing its position. A synchronous active-low reset restarts the sequence at the first stage with the counter cleared.

Top module: `stage_enable_seq`

## Requirements
- R1: While `run` is high, a window lasts DWELL_CYCLES consecutive run cycles (100 by default, which is 2 µs at 50 MHz). The current stage's enable is high for exactly one cycle, the last cycle of the window, which is the DWELL_CYCLES-th run cycle since the window began.
- R2: `stage_en[k]` is the enable of stage k. At most one bit of `stage_en` is high in any cycle. Successive pulses step through the stages in ascending index order 0, 1, 2, and so on.
- R3: The pulse that follows the pulse of stage NUM_STAGES-1 (bit 9 by default) is the pulse of stage 0.
- R4: `frame_stb` is high exactly in the cycles where `stage_en[NUM_STAGES-1]` is high. While `run` stays high, consecutive strobes are NUM_STAGES*DWELL_CYCLES cycles apart (1000 cycles, 20 µs).
- R5: In any cycle with `run` low, all of `stage_en` and `frame_stb` are low, and the cycle count and stage index hold. When `run` returns high, the window continues from the point where it stopped.
- R6: A rising clock edge with `rst_n` low sets the sequencer to stage 0, cycle 0. While `rst_n` is low, `stage_en` and `frame_stb` are low. After release, the first pulse is `stage_en[0]`, and it comes in the DWELL_CYCLES-th run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High to advance the sequence; low pauses it |
| stage_en | output | NUM_STAGES | One-cycle enable for each pipeline stage register |
| frame_stb | output | 1 | Pulses with the last stage's enable to mark a new output |

## Verification
The bench builds the block with its default sizing of ten stages and 100-cycle windows. At this sizing, several full 1000-cycle frames fit in a short run, so the bench observes the true wrap from stage 9 to stage 0 and the real 20 µs strobe spacing. The bench also pauses the sequence in the middle of a window and toggles `run` every cycle to show that partial windows are kept. It also applies a reset while running, which brings back stage 0 with a fresh window.

// File: rtl/seq_pkg.sv
// seq_pkg: shared helpers for the stage enable sequencer.
// Assumes all sizing parameters are positive integers.
package seq_pkg;

    // Width of a register that counts 0..n-1; never less than one bit.
    function automatic int unsigned width_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dwell_timer.sv
// dwell_timer: counts run cycles within one stage window and flags the
// final cycle of that window. Assumes DWELL >= 1; count holds while idle.
module dwell_timer
    import seq_pkg::*;
#(
    parameter int unsigned DWELL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned CNT_W = width_for(DWELL);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance the window count on run cycles, wrapping at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Flag the final cycle of a window that is actually being run.
    always_comb begin
        last_o = rst_n && run_i && (cnt_q == LAST_C);
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_C);

    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(cnt_q));

    p_cnt_clear_r6: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0);

endmodule

// File: rtl/stage_ring.sv
// stage_ring: holds the index of the stage that owns the current window
// and steps it in ascending order with wrap. Assumes NUM >= 1.
module stage_ring
    import seq_pkg::*;
#(
    parameter int unsigned NUM = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_i,
    output logic [width_for(NUM)-1:0] idx_o
);
    localparam int unsigned IDX_W = width_for(NUM);
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(NUM - 1);

    logic [IDX_W-1:0] idx_q;

    // Step to the next stage on each window end, returning to 0 after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= (idx_q == LAST_C) ? '0 : idx_q + IDX_W'(1);
        end
    end

    assign idx_o = idx_q;

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_C);

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && idx_q == LAST_C) |=> idx_q == '0);

    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(idx_q));

    p_idx_clear_r6: assert property (@(posedge clk)
        !rst_n |=> idx_q == '0);

endmodule

// File: rtl/stage_enable_seq.sv
// stage_enable_seq: rotating one-hot enable generator for a fixed-dwell
// pipeline. Each stage's enable pulses in the last cycle of its window;
// frame_stb marks the last stage. Assumes a single clock and synchronous reset.
module stage_enable_seq
    import seq_pkg::*;
#(
    parameter int unsigned NUM_STAGES   = 10,
    parameter int unsigned DWELL_CYCLES = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    output logic [NUM_STAGES-1:0] stage_en,
    output logic                  frame_stb
);
    localparam int unsigned IDX_W = width_for(NUM_STAGES);

    logic             win_end;
    logic [IDX_W-1:0] cur_idx;

    dwell_timer #(.DWELL(DWELL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .last_o(win_end)
    );

    stage_ring #(.NUM(NUM_STAGES)) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .adv_i(win_end),
        .idx_o(cur_idx)
    );

    // Decode the owning stage into its enable bit at each window end.
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_en
        assign stage_en[k] = win_end && (cur_idx == IDX_W'(k));
    end

    // Frame strobe accompanies the final stage's capture.
    assign frame_stb = win_end && (cur_idx == IDX_W'(NUM_STAGES - 1));

    p_onehot_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_en));

    p_frame_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb == stage_en[NUM_STAGES-1]);

    p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (stage_en == '0 && !frame_stb));

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (DWELL_CYCLES > 1 && stage_en != '0) |=> stage_en == '0);

endmodule

// File: tb/stage_enable_seq_tb_top.sv
module stage_enable_seq_tb_top;
    localparam int N        = 10;
    localparam int D        = 100;
    localparam int CLK_NS   = 20;
    localparam int WD_CYC   = 20000;

    typedef struct {
        logic [N-1:0] en;
        logic         fr;
        string        tag;
        bit           cont;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [N-1:0] stage_en;
    logic         frame_stb;

    item_t exp_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    drv_done = 1'b0;

    // bench model state (from the requirements)
    int m_cnt = 0;
    int m_stg = 0;

    always #(CLK_NS/2) clk = ~clk;

    stage_enable_seq #(.NUM_STAGES(N), .DWELL_CYCLES(D)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .stage_en (stage_en),
        .frame_stb(frame_stb)
    );

    // Driver: apply one cycle of stimulus and push the expected outputs.
    task automatic drive(input logic rv, input logic runv, input int ncyc,
                         input string tag, input bit cont);
        for (int i = 0; i < ncyc; i++) begin
            item_t it;
            @(negedge clk);
            rst_n = rv;
            run   = runv;
            it.tag  = tag;
            it.cont = cont;
            it.en   = '0;
            it.fr   = 1'b0;
            if (!rv) begin
                m_cnt = 0;
                m_stg = 0;
            end else begin
                if (runv && m_cnt == D-1) begin
                    it.en[m_stg] = 1'b1;
                    it.fr = (m_stg == N-1);
                end
                if (runv) begin
                    if (m_cnt == D-1) begin
                        m_cnt = 0;
                        m_stg = (m_stg == N-1) ? 0 : m_stg + 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            end
            exp_q.push_back(it);
        end
    endtask

    // Monitor: pop and compare each cycle; check strobe spacing (R4).
    initial begin
        int cyc = 0;
        int last_fr = -1;
        forever begin
            @(negedge clk);
            #1;
            cyc++;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_tests++;
                if (stage_en !== it.en) begin
                    n_fail++;
                    $display("FAIL %s stage_en cycle %0d: got %b exp %b",
                             it.tag, cyc, stage_en, it.en);
                end
                n_tests++;
                if (frame_stb !== it.fr) begin
                    n_fail++;
                    $display("FAIL R4 frame_stb cycle %0d: got %b exp %b",
                             cyc, frame_stb, it.fr);
                end
                if (!it.cont) begin
                    last_fr = -1;
                end else if (frame_stb === 1'b1) begin
                    if (last_fr >= 0) begin
                        n_tests++;
                        if (cyc - last_fr != N*D) begin
                            n_fail++;
                            $display("FAIL R4 strobe spacing: got %0d exp %0d",
                                     cyc - last_fr, N*D);
                        end
                    end
                    last_fr = cyc;
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        drive(1'b0, 1'b0, 3,    "R6", 1'b0);  // reset state
        drive(1'b1, 1'b1, 2600, "R1/R2/R3", 1'b1); // continuous: order, dwell, wrap
        drive(1'b1, 1'b1, 50,   "R1", 1'b0);
        drive(1'b1, 1'b0, 150,  "R5", 1'b0);  // pause mid-window
        drive(1'b1, 1'b1, 1500, "R5", 1'b0);  // resume from held point
        for (int i = 0; i < 200; i++) begin   // run toggling every cycle
            drive(1'b1, 1'b1, 1, "R5", 1'b0);
            drive(1'b1, 1'b0, 1, "R5", 1'b0);
        end
        drive(1'b1, 1'b1, 37,   "R1", 1'b0);
        drive(1'b0, 1'b1, 2,    "R6", 1'b0);  // reset while running
        drive(1'b1, 1'b1, 1100, "R6", 1'b0);  // first pulse is stage 0 after D cycles
        drive(1'b1, 1'b0, 5,    "R5", 1'b0);
        drv_done = 1'b1;
    end

    // Finish when the scoreboard drains.
    initial begin
        wait (drv_done);
        wait (exp_q.size() == 0);
        @(negedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_NS * WD_CYC);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule